// File: doc/BRIEF.md
# Communication Link Session Controller

This block sequences one communication session through four phases: it waits for a start command, runs a link handshake, holds an active data-transfer session and then closes the session before it accepts another start. Each phase can only be left by its own trigger, so initialization and teardown always happen in the same strict order. Upstream logic supplies debounced, clock-synchronous control inputs. The block drives a one-hot status vector for indicator LEDs and one enable strobe for each active phase: handshake, transfer and teardown.

The reset is synchronous. All outputs are registered Moore outputs that change in the same cycle as the state register, so the LEDs and enables always match the current phase. The state register can be built one-hot or binary, selected by a parameter. Any code that is not legal decodes back to the idle phase. The intended clock is 50 MHz.

Top module: `link_session_ctrl`

## Requirements
- R1: One clock edge with `rst` high puts the block in idle, with `status_led` = 4'b0001 and all three enables low.
- R2: In idle, the block stays in idle while `start_cmd` is low, whatever `link_up` and `xfer_done` are.
- R3: In idle, `start_cmd` high moves the block to the handshake phase at the next edge (`status_led` = 4'b0010).
- R4: In the handshake phase, `start_cmd` and `link_up` both high move the block to the transfer phase (`status_led` = 4'b0100). With `start_cmd` high and `link_up` low, the block stays in the handshake phase.
- R5: In the handshake phase, `start_cmd` low aborts the attempt and returns the block to idle at the next edge, even if `link_up` is high.
- R6: In the transfer phase, the block stays until `xfer_done` is high, then moves to the teardown phase (`status_led` = 4'b1000). `start_cmd` and `link_up` have no effect in this phase.
- R7: The teardown phase lasts exactly one cycle and is always followed by idle, whatever the inputs are.
- R8: `status_led` is always one-hot. Bit 0 is idle, bit 1 is handshake, bit 2 is transfer and bit 3 is teardown.
- R9: `hs_en`, `xfer_en` and `td_en` are high exactly when `status_led` bit 1, bit 2 and bit 3 are high, respectively.
- R10: The block never goes from the transfer phase directly to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 50 MHz |
| rst | input | 1 | Synchronous reset, active high |
| start_cmd | input | 1 | Start command for a session; must stay high through the handshake |
| link_up | input | 1 | The link handshake has succeeded |
| xfer_done | input | 1 | Transfer finished or termination requested |
| status_led | output | 4 | One-hot phase indicator |
| hs_en | output | 1 | Handshake phase enable |
| xfer_en | output | 1 | Transfer phase enable |
| td_en | output | 1 | Teardown phase enable |

## Verification
The bench raises `link_up` and `xfer_done` while the block is idle. A design that keyed its transitions on the wrong inputs would then start a session with no start command. It drops `start_cmd` during the handshake while `link_up` is high; a design that checked priority in the wrong order would enter the transfer phase instead of aborting. It holds `xfer_done` high for several cycles across teardown. A design that skipped the teardown phase, held it for more than one cycle, or went straight back into a session would show the wrong LED code. A reset applied in the middle of a session must clear the enables at the first edge.

// File: rtl/link_session_pkg.sv
package link_session_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_XFER  = 2'd2,
      PH_CLOSE = 2'd3
   } phase_e;

   localparam int unsigned PHASE_COUNT = 4;

   function automatic logic [PHASE_COUNT-1:0] phase_to_onehot(input phase_e p);
      logic [PHASE_COUNT-1:0] v;
      v = '0;
      v[p] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/lsc_next_phase.sv
module lsc_next_phase
   import link_session_pkg::*;
(
   input  phase_e cur_ph,
   input  logic   start_cmd,
   input  logic   link_up,
   input  logic   xfer_done,
   output phase_e nxt_ph
);
   always_comb begin
      nxt_ph = PH_IDLE;
      unique case (cur_ph)
         PH_IDLE:  nxt_ph = start_cmd ? PH_SETUP : PH_IDLE;
         PH_SETUP: begin
            if (!start_cmd)   nxt_ph = PH_IDLE;
            else if (link_up) nxt_ph = PH_XFER;
            else              nxt_ph = PH_SETUP;
         end
         PH_XFER:  nxt_ph = xfer_done ? PH_CLOSE : PH_XFER;
         PH_CLOSE: nxt_ph = PH_IDLE;
         default:  nxt_ph = PH_IDLE;
      endcase
   end
endmodule

// File: rtl/lsc_phase_reg.sv
module lsc_phase_reg
   import link_session_pkg::*;
#(
   parameter bit USE_ONEHOT = 1'b1
) (
   input  logic   clk,
   input  logic   rst,
   input  phase_e nxt_ph,
   output phase_e cur_ph
);
   localparam int unsigned CODE_W = USE_ONEHOT ? PHASE_COUNT : 2;

   logic [CODE_W-1:0] code_q;

   generate
      if (USE_ONEHOT) begin : g_onehot
         localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(1);
         always_ff @(posedge clk) begin
            if (rst) code_q <= RST_CODE;
            else     code_q <= CODE_W'(phase_to_onehot(nxt_ph));
         end
         always_comb begin
            case (code_q)
               CODE_W'(4'b0010): cur_ph = PH_SETUP;
               CODE_W'(4'b0100): cur_ph = PH_XFER;
               CODE_W'(4'b1000): cur_ph = PH_CLOSE;
               default:          cur_ph = PH_IDLE;
            endcase
         end
      end else begin : g_binary
         always_ff @(posedge clk) begin
            if (rst) code_q <= CODE_W'(PH_IDLE);
            else     code_q <= CODE_W'(nxt_ph);
         end
         always_comb cur_ph = phase_e'(code_q);
      end
   endgenerate
endmodule

// File: rtl/lsc_out_reg.sv
module lsc_out_reg
   import link_session_pkg::*;
#(
   parameter int unsigned LED_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  phase_e           nxt_ph,
   output logic [LED_W-1:0] status_led,
   output logic             hs_en,
   output logic             xfer_en,
   output logic             td_en
);
   always_ff @(posedge clk) begin
      if (rst) begin
         status_led <= LED_W'(1);
         hs_en      <= 1'b0;
         xfer_en    <= 1'b0;
         td_en      <= 1'b0;
      end else begin
         status_led <= LED_W'(phase_to_onehot(nxt_ph));
         hs_en      <= (nxt_ph == PH_SETUP);
         xfer_en    <= (nxt_ph == PH_XFER);
         td_en      <= (nxt_ph == PH_CLOSE);
      end
   end
endmodule

// File: rtl/link_session_ctrl.sv
module link_session_ctrl
   import link_session_pkg::*;
#(
   parameter int unsigned LED_W      = 4,
   parameter bit          USE_ONEHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_cmd,
   input  logic             link_up,
   input  logic             xfer_done,
   output logic [LED_W-1:0] status_led,
   output logic             hs_en,
   output logic             xfer_en,
   output logic             td_en
);
   generate
      if (LED_W != PHASE_COUNT) begin : g_bad_width
         $error("LED_W must equal the number of phases");
      end
   endgenerate

   phase_e cur_ph;
   phase_e nxt_ph;

   lsc_next_phase u_next (
      .cur_ph(cur_ph), .start_cmd(start_cmd), .link_up(link_up),
      .xfer_done(xfer_done), .nxt_ph(nxt_ph)
   );

   lsc_phase_reg #(.USE_ONEHOT(USE_ONEHOT)) u_state (
      .clk(clk), .rst(rst), .nxt_ph(nxt_ph), .cur_ph(cur_ph)
   );

   lsc_out_reg #(.LED_W(LED_W)) u_out (
      .clk(clk), .rst(rst), .nxt_ph(nxt_ph), .status_led(status_led),
      .hs_en(hs_en), .xfer_en(xfer_en), .td_en(td_en)
   );

   assert_led_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $countones(status_led) == 1);
   assert_en_match_R9: assert property (@(posedge clk) disable iff (rst)
      (hs_en == status_led[1]) && (xfer_en == status_led[2]) && (td_en == status_led[3]));
   assert_leds_track_state_R9: assert property (@(posedge clk) disable iff (rst)
      status_led[cur_ph] == 1'b1);
   assert_close_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      td_en |=> status_led[0]);
   assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
      (hs_en && !start_cmd) |=> status_led[0]);
   assert_no_skip_R10: assert property (@(posedge clk) disable iff (rst)
      xfer_en |=> !status_led[0]);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (status_led[0] && !start_cmd) |=> status_led[0]);
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (status_led == LED_W'(1)) && !hs_en && !xfer_en && !td_en);
endmodule

// File: tb/link_session_ctrl_tb_top.sv
module link_session_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_cmd = 1'b0, link_up = 1'b0, xfer_done = 1'b0;
   logic [3:0] status_led;
   logic hs_en, xfer_en, td_en;
   int checks = 0;
   int errors = 0;
   int model_ph = 0;

   always #10 clk = ~clk;

   link_session_ctrl dut_i (
      .clk(clk), .rst(rst), .start_cmd(start_cmd), .link_up(link_up),
      .xfer_done(xfer_done), .status_led(status_led), .hs_en(hs_en),
      .xfer_en(xfer_en), .td_en(td_en)
   );

   task automatic step(input logic r, input logic s, input logic l,
                       input logic d, input string tag);
      logic [3:0] exp_led;
      rst = r; start_cmd = s; link_up = l; xfer_done = d;
      @(posedge clk);
      if (r) model_ph = 0;
      else begin
         case (model_ph)
            0: model_ph = s ? 1 : 0;
            1: model_ph = !s ? 0 : (l ? 2 : 1);
            2: model_ph = d ? 3 : 2;
            default: model_ph = 0;
         endcase
      end
      @(negedge clk);
      exp_led = 4'b0001 << model_ph;
      checks++;
      if (status_led !== exp_led || hs_en !== exp_led[1] ||
          xfer_en !== exp_led[2] || td_en !== exp_led[3]) begin
         errors++;
         $display("FAIL %s: led=%b en=%b%b%b expected led=%b en=%b%b%b", tag,
                  status_led, hs_en, xfer_en, td_en,
                  exp_led, exp_led[1], exp_led[2], exp_led[3]);
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(1, 0, 0, 0, "R1 reset");
      step(0, 0, 1, 1, "R2 idle ignores link_up/xfer_done");
      step(0, 0, 0, 1, "R2 idle hold");
      step(0, 1, 0, 0, "R3 start to setup");
      step(0, 1, 0, 0, "R4 setup wait");
      step(0, 0, 1, 0, "R5 abort with link_up high");
      step(0, 1, 0, 0, "R3 start again");
      step(0, 1, 1, 0, "R4 setup to xfer");
      step(0, 0, 0, 0, "R6 xfer ignores start low");
      step(0, 1, 1, 0, "R6 xfer hold");
      step(0, 1, 1, 1, "R6 xfer to close");
      step(0, 1, 1, 1, "R7 close to idle");
      step(0, 1, 1, 1, "R3 restart after close");
      step(0, 1, 1, 1, "R4 direct link");
      step(0, 0, 0, 1, "R10 xfer not to idle");
      step(0, 0, 0, 0, "R7 idle after close");
      step(0, 1, 0, 0, "R3 start");
      step(0, 1, 1, 0, "R4 to xfer");
      step(1, 1, 1, 0, "R1 reset mid session");
      step(0, 0, 0, 0, "R8 idle one-hot");
      for (int i = 0; i < 20; i++)
         step(0, (i % 3) != 0, (i % 4) == 1, (i % 5) == 2, "R9 mixed pattern");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule